// File: doc/BRIEF.md
# Conversion Result Register Bank

This block keeps the most recent 10-bit result for each of four converter result slots. A CPU reads the slots over an 8-bit bus. On its input side, a one-cycle conversion strobe arrives with a 3-bit channel number and a 10-bit value. The block writes that value into the slot that serves the channel. Channels n and n+4 share slot n, so the upper channel group 4..7 reaches slots 0..3 in order. Each slot is presented as a 16-bit word. The result occupies bits 15..6 and bits 5..0 are zero.

The CPU reads one byte per cycle. The read address uses bit 0 to pick the half of the word: 0 selects the upper byte and 1 selects the lower byte. Address bits 2..1 pick the slot. An upper-byte read returns the live upper byte combinationally. In the same cycle it copies that slot's lower byte into one holding byte that all slots share. A lower-byte read then returns the holding byte, whatever slot its address names. Reading the upper byte first and the lower byte next therefore yields a consistent 16-bit value, even if a new conversion lands between the two reads. The CPU has no write path into the slots.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every upper-byte and lower-byte read returns 0x00, since all four slots and the holding byte are cleared.
- R2: When cv_valid is high at a clock edge, cv_data is stored into slot (cv_chan mod 4), so channels 4..7 map to slots 0..3. The new value is readable from the next cycle on.
- R3: While rd_en is high and rd_addr[0] is 0, rd_data equals result bits 9..2 of slot rd_addr[2:1] in that same cycle.
- R4: While rd_en is high and rd_addr[0] is 1, rd_data equals the holding byte: bits 7..6 carry result bits 1..0 of the slot captured last, and bits 5..0 are always zero.
- R5: An upper-byte read loads the holding byte at that clock edge with the lower byte of the addressed slot. No other operation changes the holding byte.
- R6: A conversion written between an upper-byte read and the following lower-byte read does not change the value that the lower-byte read returns.
- R7: When a conversion and an upper-byte read of the same slot occur in the same cycle, the read and the holding byte both take the old value, and the new value appears from the next cycle.
- R8: While rd_en is low, rd_data is 0x00.
- R9: A conversion changes only the slot that its channel selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cv_valid | input | 1 | Conversion-complete strobe |
| cv_chan | input | 3 | Channel number of the completed conversion |
| cv_data | input | 10 | Conversion result |
| rd_en | input | 1 | CPU byte read strobe |
| rd_addr | input | 3 | Byte address: bits 2..1 slot, bit 0 half (0 upper, 1 lower) |
| rd_data | output | 8 | Read byte, combinational |

## Verification
Read data is combinational, so every read result is due in the cycle that the read is issued. The bench samples rd_data a few nanoseconds after it drives the inputs on the falling edge, before the next rising edge. Stored slots and the holding byte change at the rising edge, so their effects are due from the next cycle. The bench updates its own model just after each rising edge, capturing the holding byte from the model's pre-update slot value. This reproduces the same-cycle collision ordering without reference to the RTL.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  localparam int RES_W  = 10;
  localparam int WORD_W = 16;
  localparam int BUS_W  = 8;
  localparam int PAD_W  = WORD_W - RES_W;

  typedef logic [RES_W-1:0]  res_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BUS_W-1:0]  byte_t;

  // Left-justify a result into its 16-bit word
  function automatic word_t pack_word(input res_t r);
    return {r, {PAD_W{1'b0}}};
  endfunction

  function automatic byte_t hi_byte(input word_t w);
    return w[WORD_W-1 -: BUS_W];
  endfunction

  function automatic byte_t lo_byte(input word_t w);
    return w[BUS_W-1:0];
  endfunction
endpackage

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_bank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CH_W     = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cv_valid,
  input  logic [CH_W-1:0]         cv_chan,
  input  res_t                    cv_data,
  output word_t [NUM_REGS-1:0]    words
);
  logic [REG_W-1:0]    slot_idx;
  logic [NUM_REGS-1:0] upd_hit;

  assign slot_idx = REG_W'(cv_chan % NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign upd_hit[g] = cv_valid && (slot_idx == REG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          words[g] <= '0;
      else if (upd_hit[g]) words[g] <= pack_word(cv_data);
    end

    // R2
    store_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cv_valid && ((cv_chan % NUM_REGS) == g) |=> words[g][WORD_W-1 -: RES_W] == $past(cv_data));
    // R9
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cv_valid && ((cv_chan % NUM_REGS) == g)) |=> $stable(words[g]));
  end

  // R9
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_hit));
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_bank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  word_t [NUM_REGS-1:0] words,
  input  logic                 rd_en,
  input  logic [REG_W:0]       rd_addr,
  output byte_t                rd_data
);
  logic [REG_W-1:0] rd_sel;
  logic             want_hi;
  logic             up_read;
  byte_t            tmp_q;
  word_t            sel_word;

  assign rd_sel   = rd_addr[REG_W:1];
  assign want_hi  = ~rd_addr[0];
  assign up_read  = rd_en && want_hi;
  assign sel_word = words[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmp_q <= '0;
    else if (up_read) tmp_q <= lo_byte(sel_word);
  end

  always_comb begin
    if (!rd_en)       rd_data = '0;
    else if (want_hi) rd_data = hi_byte(sel_word);
    else              rd_data = tmp_q;
  end

  // R5
  tmp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_read |=> tmp_q == $past(lo_byte(sel_word)));
  // R5
  tmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_read |=> $stable(tmp_q));
  // R4
  lo_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr[0] |-> rd_data[PAD_W-1:0] == '0);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int CH_W     = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cv_valid,
  input  logic [CH_W-1:0]       cv_chan,
  input  logic [RES_W-1:0]      cv_data,
  input  logic                  rd_en,
  input  logic [REG_W:0]        rd_addr,
  output logic [BUS_W-1:0]      rd_data
);
  word_t [NUM_REGS-1:0] words;

  adc_result_store #(.NUM_REGS(NUM_REGS), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid),
    .cv_chan(cv_chan), .cv_data(cv_data), .words(words)
  );

  adc_byte_reader #(.NUM_REGS(NUM_REGS)) u_reader (
    .clk(clk), .rst_n(rst_n), .words(words),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/adc_result_bank_bench.sv
module adc_result_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv_valid = 1'b0;
  logic [2:0] cv_chan = '0;
  logic [9:0] cv_data = '0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [9:0] m_res [4];
  logic [7:0] m_tmp;

  always #10 clk = ~clk;

  adc_result_bank u_adc_result_bank (
    .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_chan(cv_chan),
    .cv_data(cv_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_read(input logic en, input logic [2:0] a);
    if (!en) return 8'h00;
    if (!a[0]) return m_res[a[2:1]][9:2];
    return m_tmp;
  endfunction

  function automatic logic [7:0] exp_lo(input logic [9:0] r);
    return {r[1:0], 6'b000000};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, sample read, then update model after rising edge
  task automatic step(input string req, input logic v, input logic [2:0] ch,
                      input logic [9:0] d, input logic re, input logic [2:0] a);
    @(negedge clk);
    cv_valid = v; cv_chan = ch; cv_data = d; rd_en = re; rd_addr = a;
    #3;
    check(req, rd_data, exp_read(re, a));
    @(posedge clk);
    #1;
    if (re && !a[0]) m_tmp = exp_lo(m_res[a[2:1]]);
    if (v) m_res[ch[1:0]] = d;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_res[i] = '0;
    m_tmp = '0;
    repeat (3) @(posedge clk);
    // R1 reset values
    for (int a = 0; a < 8; a++) step("R1", 1'b0, 3'd0, 10'd0, 1'b1, 3'(a));
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) step("R1", 1'b0, 3'd0, 10'd0, 1'b1, 3'(a));
    // R2 upper-group channels 4..7 to slots 0..3
    step("R2", 1'b1, 3'd4, 10'h3FF, 1'b0, 3'd0);
    step("R2", 1'b1, 3'd5, 10'h155, 1'b0, 3'd0);
    step("R2", 1'b1, 3'd6, 10'h2AA, 1'b0, 3'd0);
    step("R2", 1'b1, 3'd7, 10'h0C3, 1'b0, 3'd0);
    for (int s = 0; s < 4; s++) begin
      step("R3", 1'b0, 3'd0, 10'd0, 1'b1, 3'(s * 2));
      step("R4", 1'b0, 3'd0, 10'd0, 1'b1, 3'(s * 2 + 1));
    end
    // R9 channel 1 touches only slot 1
    step("R9", 1'b1, 3'd1, 10'h001, 1'b0, 3'd0);
    for (int s = 0; s < 4; s++) step("R9", 1'b0, 3'd0, 10'd0, 1'b1, 3'(s * 2));
    // R6 update between upper and lower read
    step("R6", 1'b0, 3'd0, 10'd0, 1'b1, 3'd4);
    step("R6", 1'b1, 3'd2, 10'h001, 1'b0, 3'd0);
    step("R6", 1'b0, 3'd0, 10'd0, 1'b1, 3'd5);
    check("R6", m_tmp, 8'h80);
    // R7 collision: slot 3 read and written in one cycle
    step("R7", 1'b1, 3'd3, 10'h3FE, 1'b1, 3'd6);
    step("R7", 1'b0, 3'd0, 10'd0, 1'b1, 3'd7);
    check("R7", m_tmp, 8'hC0);
    step("R7", 1'b0, 3'd0, 10'd0, 1'b1, 3'd6);
    // R5 holding byte shared; idle reads
    step("R5", 1'b0, 3'd0, 10'd0, 1'b1, 3'd1);
    step("R8", 1'b1, 3'd0, 10'h123, 1'b0, 3'd2);
    step("R5", 1'b0, 3'd0, 10'd0, 1'b1, 3'd3);
    // Random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++)
      step("R2/R3/R4/R5", 1'($urandom % 2), 3'($urandom), 10'($urandom),
           1'($urandom % 4 != 0), 3'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule